// File: doc/BRIEF.md
# Synchronous Parity-Framed Serial Transceiver

This block moves byte-wide characters over a single shared data line that is timed by a serial clock supplied from outside. The line is modelled as three signals: an input, an output and an output enable. The transmit path takes a byte, or a request for a break, through a valid/ready handshake. It then drives one fixed frame onto the line and releases the line when the frame is done. The receive path watches the line and removes the framing. It presents each byte with a parity-error flag and a framing-error flag. When the line stays low long enough to be a break rather than a character, it raises a one-cycle break flag instead.

Every frame has the same layout: a low start bit, eight data bits sent least significant first, an even parity bit, and two high stop bits. A break is the line held low for twelve bit times or longer. The serial clock is treated as an ordinary signal and sampled in the core clock domain. Its rising edges are the receive sampling points, and its falling edges are the transmit update points. A level enable input switches the link on and off. While it is low the line is released and all partial work is dropped.

Top module: `sync_frame_link`

## Requirements
- R1: A transmitted character appears on `line_o` as 12 bit periods in this order: start bit 0, data bits D0 (bit 0 of `tx_data`) through D7, parity, then two stop bits of 1. `line_oe` is high for the whole frame and low again one bit period after the second stop bit.
- R2: The parity bit is the XOR of the eight data bits (even parity). This holds for transmit, and the receiver checks against it.
- R3: `line_o` changes only in the core cycle after a falling edge of `sclk_i`, or when the link is disabled or reset. The receiver samples `line_i` at rising edges of `sclk_i`.
- R4: `tx_ready` is high only while `en` is high and no transmission is in progress. A request is taken in a cycle where `tx_valid` and `tx_ready` are both high. `line_oe` rises only after such a cycle.
- R5: A request with `tx_brk` high sends 12 bit periods of 0, then 2 bit periods of 1, and then releases the line.
- R6: A received character is shown on `rx_data` with `rx_valid` high. `rx_valid` stays high until a cycle with `rx_ready` high. `rx_perr` is 1 when the received parity bit differs from the XOR of the received data bits.
- R7: `rx_ferr` is 1 when either received stop bit is 0.
- R8: Twelve consecutive low samples, counted from the start bit, produce exactly one single-cycle `rx_break` pulse and no character. A low that lasts longer is still a single break. The receiver does not look for a new start bit until it has sampled the line high.
- R9: A start bit that directly follows the second stop bit, with no idle bit between them, is received as a new frame.
- R10: While `en` is low, `line_oe` and `tx_ready` are low, `line_o` is 1 and `rx_valid` is 0. Any character being sent or received at that moment is dropped.
- R11: After reset `line_oe` is 0, `line_o` is 1 and `rx_valid` is 0. `tx_ready` follows `en`.
- R12: `line_o` is 1 whenever `line_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Link active when high |
| sclk_i | input | 1 | External serial bit clock |
| line_i | input | 1 | Data line as seen at the pin |
| line_o | output | 1 | Value driven onto the data line |
| line_oe | output | 1 | Output enable for the data line |
| tx_data | input | 8 | Byte to transmit |
| tx_brk | input | 1 | Send a break instead of `tx_data` |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can take a request |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity mismatch on the received byte |
| rx_ferr | output | 1 | A stop bit of the received byte was low |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Host takes the pending byte |
| rx_break | output | 1 | One-cycle pulse on a detected break |

## Verification
Both paths are driven with directed bytes of even and odd bit count, all-zero and all-one bytes, and random bytes. The even/odd cases separate a correct parity bit from an inverted or missing one, and the all-zero/all-one cases expose bit-order and shift-count errors. On receive, the parity bit and each stop bit are corrupted on their own and in random mixes, so that parity errors and framing errors are told apart from each other and from good frames. Low runs of 11, 12 and 25 bits separate a character with a framing error from a break, and a single break from repeated pulses. Back-to-back frames and an enable drop in the middle of a frame show whether the start of a frame, and the discarding of a partial frame, are handled correctly.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 4;          // start + data + parity + 2 stops
    localparam int BRK_BITS   = FRAME_BITS;          // low run that counts as a break
    localparam int BRK_TAIL   = 2;                   // high bits after a sent break
    localparam int TX_MAX     = BRK_BITS + BRK_TAIL;
    localparam int CNT_W      = $clog2(TX_MAX + 1);
    localparam int SH_W       = FRAME_BITS - 1;      // bits after the start bit

    typedef enum logic {TX_IDLE, TX_BUSY} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_FRAME, RX_HOLD} rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    function automatic logic even_par(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction

    // Line order from bit 0 upward; unused upper bits are idle-high.
    function automatic logic [TX_MAX-1:0] char_frame(input logic [DATA_W-1:0] d);
        logic [TX_MAX-1:0] f;
        f = '1;
        f[0] = 1'b0;
        f[DATA_W:1] = d;
        f[DATA_W+1] = even_par(d);
        return f;
    endfunction

    function automatic logic [TX_MAX-1:0] break_frame();
        logic [TX_MAX-1:0] f;
        f = '1;
        f[BRK_BITS-1:0] = '0;
        return f;
    endfunction

    function automatic rx_char_t decode(input logic [SH_W-1:0] f);
        rx_char_t c;
        c.data = f[DATA_W-1:0];
        c.perr = even_par(f[DATA_W-1:0]) ^ f[DATA_W];
        c.ferr = ~(f[DATA_W+1] & f[DATA_W+2]);
        return c;
    endfunction

endpackage

// File: rtl/sfl_edge.sv
module sfl_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_i;
    end

    assign rise = sclk_i & ~sclk_q;
    assign fall = ~sclk_i & sclk_q;
endmodule

// File: rtl/sfl_tx.sv
module sfl_tx
    import sfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              fall,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_brk,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_o,
    output logic              line_oe
);
    tx_state_e         state;
    logic [TX_MAX-1:0] sr;
    logic [CNT_W-1:0]  left;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= TX_IDLE;
            sr     <= '0;
            left   <= '0;
            line_o <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (tx_valid) begin
                        sr    <= tx_brk ? break_frame() : char_frame(tx_data);
                        left  <= tx_brk ? CNT_W'(TX_MAX) : CNT_W'(FRAME_BITS);
                        state <= TX_BUSY;
                    end
                end
                default: begin
                    if (fall) begin
                        if (left != '0) begin
                            line_o <= sr[0];
                            sr     <= sr >> 1;
                            left   <= left - 1'b1;
                        end else begin
                            line_o <= 1'b1;
                            state  <= TX_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    assign tx_ready = en && (state == TX_IDLE);
    assign line_oe  = (state == TX_BUSY);
endmodule

// File: rtl/sfl_rx.sv
module sfl_rx
    import sfl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     rise,
    input  logic     line_i,
    input  logic     rx_ready,
    output rx_char_t rx_char,
    output logic     rx_valid,
    output logic     rx_break
);
    rx_state_e        state;
    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] k;
    logic             all_low;
    logic [SH_W-1:0]  sh_next;

    assign sh_next = {line_i, sh[SH_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state    <= RX_IDLE;
            sh       <= '0;
            k        <= '0;
            all_low  <= 1'b0;
            rx_char  <= '0;
            rx_valid <= 1'b0;
            rx_break <= 1'b0;
        end else begin
            rx_break <= 1'b0;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (rise) begin
                case (state)
                    RX_IDLE: begin
                        if (!line_i) begin
                            state   <= RX_FRAME;
                            k       <= '0;
                            all_low <= 1'b1;
                        end
                    end
                    RX_FRAME: begin
                        sh      <= sh_next;
                        all_low <= all_low & ~line_i;
                        k       <= k + 1'b1;
                        if (k == CNT_W'(SH_W - 1)) begin
                            if (all_low && !line_i) begin
                                rx_break <= 1'b1;
                                state    <= RX_HOLD;
                            end else begin
                                rx_char  <= decode(sh_next);
                                rx_valid <= 1'b1;
                                state    <= RX_IDLE;
                            end
                        end
                    end
                    default: begin
                        if (line_i) state <= RX_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sync_frame_link.sv
module sync_frame_link
    import sfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sclk_i,
    input  logic              line_i,
    output logic              line_o,
    output logic              line_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_brk,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_break
);
    logic     rise, fall;
    rx_char_t rx_char;

    sfl_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .rise   (rise),
        .fall   (fall)
    );

    sfl_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .fall     (fall),
        .tx_data  (tx_data),
        .tx_brk   (tx_brk),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .line_o   (line_o),
        .line_oe  (line_oe)
    );

    sfl_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .rise     (rise),
        .line_i   (line_i),
        .rx_ready (rx_ready),
        .rx_char  (rx_char),
        .rx_valid (rx_valid),
        .rx_break (rx_break)
    );

    assign rx_data = rx_char.data;
    assign rx_perr = rx_char.perr;
    assign rx_ferr = rx_char.ferr;
endmodule

// File: rtl/sfl_chk.sv
module sfl_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic sclk_i,
    input logic line_o,
    input logic line_oe,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_ready,
    input logic rx_break
);
    // R12: a released line reads high
    p_release_high_r12: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> line_o);

    // R4: no new request is taken while a frame is on the line
    p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> !tx_ready);

    // R4: driving starts only after a handshake
    p_oe_after_handshake_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(line_oe) |-> $past(tx_valid && tx_ready));

    // R3: line updates follow a falling serial clock edge
    p_update_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en) && !$stable(line_o))
            |-> (!$past(sclk_i) && $past(sclk_i, 2)));

    // R10: disabling releases the line and drops pending data
    p_disable_clears_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!line_oe && !rx_valid));

    // R6: a pending byte waits for the host
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready && en) |=> rx_valid);

    // R8: break indication is a single-cycle pulse
    p_break_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rx_break |=> !rx_break);
endmodule

bind sync_frame_link sfl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sclk_i   (sclk_i),
    .line_o   (line_o),
    .line_oe  (line_oe),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_break (rx_break)
);

// File: tb/tb_sync_frame_link.sv
`timescale 1ns/1ps
module tb_sync_frame_link;
    logic       clk = 1'b0;
    logic       rst, en, sclk_i, line_i;
    logic       line_o, line_oe;
    logic [7:0] tx_data;
    logic       tx_brk, tx_valid, tx_ready;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_valid, rx_ready, rx_break;

    int total = 0;
    int bad   = 0;
    int brk_seen = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sync_frame_link dut (
        .clk(clk), .rst(rst), .en(en), .sclk_i(sclk_i), .line_i(line_i),
        .line_o(line_o), .line_oe(line_oe),
        .tx_data(tx_data), .tx_brk(tx_brk), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_break(rx_break)
    );

    always @(negedge clk) if (!rst && rx_break) brk_seen++;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Line bits in sending order: index 0 is the start bit.
    function automatic logic [11:0] mk_frame(input logic [7:0] d, input bit bad_p,
                                             input bit bad_s1, input bit bad_s2);
        logic [11:0] f;
        logic p;
        p = 1'b0;
        for (int i = 0; i < 8; i++) p = p ^ d[i];
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[i+1] = d[i];
        f[9]  = p ^ bad_p;
        f[10] = ~bad_s1;
        f[11] = ~bad_s2;
        return f;
    endfunction

    // One serial bit: falling edge with new receive bit, then rising edge.
    task automatic bit_cycle(input logic rxb, output logic txb, output logic txoe);
        @(negedge clk);
        sclk_i = 1'b0;
        line_i = rxb;
        repeat (3) @(negedge clk);
        txb  = line_o;
        txoe = line_oe;
        sclk_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic feed(input logic [11:0] f, input int n);
        logic a, b;
        for (int i = 0; i < n; i++) bit_cycle(f[i], a, b);
    endtask

    task automatic feed_level(input logic v, input int n);
        logic a, b;
        for (int i = 0; i < n; i++) bit_cycle(v, a, b);
    endtask

    task automatic send_tx(input logic [7:0] d, input bit brk, input string tag);
        logic [13:0] exp, got;
        logic b, oe;
        int n, oe_ok;
        n = brk ? 14 : 12;
        exp = brk ? 14'b11_0000_0000_0000 : {2'b11, mk_frame(d, 0, 0, 0)};
        chk({tag, " R4 ready before request"}, tx_ready, 1);
        @(negedge clk);
        tx_data = d; tx_brk = brk; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0; tx_brk = 1'b0;
        chk({tag, " R4 ready drops while busy"}, tx_ready, 0);
        got = '1;
        oe_ok = 1;
        for (int i = 0; i < n; i++) begin
            bit_cycle(1'b1, b, oe);
            got[i] = b;
            if (oe !== 1'b1) oe_ok = 0;
        end
        chk({tag, brk ? " R5 break bits" : " R1 R2 frame bits"}, got, exp);
        chk({tag, " R1 oe held during frame"}, oe_ok, 1);
        bit_cycle(1'b1, b, oe);
        chk({tag, " R1 oe released after frame"}, oe, 0);
        chk({tag, " R12 released line high"}, b, 1);
    endtask

    task automatic ack_rx(input string tag);
        chk({tag, " R6 valid before ack"}, rx_valid, 1);
        @(negedge clk); rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
        chk({tag, " R6 valid cleared by ack"}, rx_valid, 0);
    endtask

    task automatic rx_expect(input logic [7:0] d, input bit p, input bit f, input string tag);
        chk({tag, " R6 rx_valid"}, rx_valid, 1);
        chk({tag, " R6 rx_data"}, rx_data, d);
        chk({tag, " R6 R2 rx_perr"}, rx_perr, p);
        chk({tag, " R7 rx_ferr"}, rx_ferr, f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int b0;
        logic [7:0] d;
        bit bp, bs1, bs2;
        logic b, oe;
        void'($urandom(32'h5EED_1234));
        rst = 1; en = 1; sclk_i = 1; line_i = 1;
        tx_data = 0; tx_brk = 0; tx_valid = 0; rx_ready = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11 reset rx_valid", rx_valid, 0);
        chk("R11 reset line_oe", line_oe, 0);
        chk("R11 reset line_o", line_o, 1);
        chk("R11 reset tx_ready", tx_ready, 1);

        // Transmit: directed bytes then random ones
        send_tx(8'hA5, 0, "tx A5");
        send_tx(8'h00, 0, "tx 00");
        send_tx(8'hFF, 0, "tx FF");
        send_tx(8'h01, 0, "tx 01");
        send_tx(8'h80, 0, "tx 80");
        send_tx(8'h00, 1, "tx break");
        for (int i = 0; i < 12; i++) send_tx(8'($urandom), 0, "tx random");

        // Receive: directed frames
        feed(mk_frame(8'h3C, 0, 0, 0), 12);
        rx_expect(8'h3C, 0, 0, "rx good");
        feed_level(1'b1, 1);
        chk("R6 valid held without ack", rx_valid, 1);
        ack_rx("rx good");
        feed(mk_frame(8'h5B, 1, 0, 0), 12);
        rx_expect(8'h5B, 1, 0, "rx parity err"); ack_rx("rx parity err");
        feed(mk_frame(8'h77, 0, 1, 0), 12);
        rx_expect(8'h77, 0, 1, "rx stop1 low"); ack_rx("rx stop1 low");
        feed(mk_frame(8'h10, 0, 0, 1), 12);
        rx_expect(8'h10, 0, 1, "rx stop2 low"); ack_rx("rx stop2 low");

        // R9 back-to-back frames, no idle bit between
        feed(mk_frame(8'hC3, 0, 0, 0), 12);
        rx_expect(8'hC3, 0, 0, "R9 first"); ack_rx("R9 first");
        feed(mk_frame(8'h96, 0, 0, 0), 12);
        rx_expect(8'h96, 0, 0, "R9 second"); ack_rx("R9 second");

        // R8 breaks
        b0 = brk_seen;
        feed_level(1'b0, 12);
        feed_level(1'b1, 1);
        chk("R8 one pulse for 12 lows", brk_seen - b0, 1);
        chk("R8 no character on break", rx_valid, 0);
        b0 = brk_seen;
        feed_level(1'b0, 25);
        feed_level(1'b1, 1);
        chk("R8 one pulse for long low", brk_seen - b0, 1);
        chk("R8 no character on long break", rx_valid, 0);
        b0 = brk_seen;
        feed_level(1'b0, 11);
        feed_level(1'b1, 1);
        chk("R8 eleven lows no break", brk_seen - b0, 0);
        rx_expect(8'h00, 0, 1, "R8 eleven lows is char"); ack_rx("R8 eleven lows");
        feed(mk_frame(8'h42, 0, 0, 0), 12);
        rx_expect(8'h42, 0, 0, "R8 frame after break"); ack_rx("R8 frame after break");

        // Receive: random frames with random faults
        for (int i = 0; i < 20; i++) begin
            d = 8'($urandom);
            bp = ($urandom % 4) == 0;
            bs1 = ($urandom % 4) == 0;
            bs2 = ($urandom % 4) == 0;
            if (mk_frame(d, bp, bs1, bs2) == 12'h000) bs2 = 0;
            b0 = brk_seen;
            feed(mk_frame(d, bp, bs1, bs2), 12);
            rx_expect(d, bp, bs1 | bs2, "rx random");
            chk("R8 no break on random frame", brk_seen - b0, 0);
            ack_rx("rx random");
        end

        // R10 enable drop during transmit
        @(negedge clk);
        tx_data = 8'h5A; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        feed_level(1'b1, 3);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R10 oe low when disabled", line_oe, 0);
        chk("R10 line high when disabled", line_o, 1);
        chk("R10 ready low when disabled", tx_ready, 0);
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        chk("R10 ready back after enable", tx_ready, 1);
        bit_cycle(1'b1, b, oe);
        chk("R10 no resumed frame", oe, 0);

        // R10 pending byte and partial frame dropped
        feed(mk_frame(8'h81, 0, 0, 0), 12);
        chk("R10 byte pending before drop", rx_valid, 1);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        chk("R10 pending byte cleared", rx_valid, 0);
        feed(mk_frame(8'hE7, 0, 0, 0), 5);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        feed_level(1'b1, 2);
        chk("R10 partial frame not delivered", rx_valid, 0);
        feed(mk_frame(8'h24, 0, 0, 0), 12);
        rx_expect(8'h24, 0, 0, "R10 frame after re-enable");
        ack_rx("R10 frame after re-enable");

        finish_run();
    end
endmodule